// File: doc/BRIEF.md
# Three-channel programmable interval timer

The block holds three independent 16-bit down-counters behind one byte-wide register bus. Each counter has a data port. A shared control port programs the counter, its byte access order and its waveform. A control write can instead snapshot a counter's count, or snapshot the count and a status byte of several counters at once. All three counters step on a common count strobe, `tick`, and each counter's `gate` input pauses its counting. Counter 0's output doubles as an interrupt request.

Software first writes a control byte that picks the mode and access order. It then writes the reload value in one or two bytes. The value is moved into the counting element on the next `tick` after the last byte of the sequence. Reads return either the live count or a held snapshot, in the byte order set by the access mode.

Top module: `interval_timer`

## Requirements
- R1: After reset every output pin and `irq` are low. A status read-back of any counter returns 0x40, which is output low, null-count set and all control bits zero.
- R2: Offsets 0, 1 and 2 are the counter data ports and offset 3 is the control port. In a control byte, bits 7:6 pick counter 0, 1 or 2 (00, 01, 10), or 11 for read-back. When a control byte with a non-zero access field is written, the output goes low for mode 000 and high for modes 011 and 100.
- R3: Control bits 5:4 set the access order. 01 uses the low byte only, and a low-only load clears the high byte. 10 uses the high byte only, and a high-only load clears the low byte. 11 uses the low byte first and then the high byte, for both loads and reads. The count is not used until the whole sequence has been written, and it enters the counter on the next `tick`.
- R4: A control byte with access field 00 snapshots the count of the selected counter. The next data-port reads return the snapshot in the programmed byte order while the live count keeps moving. A second snapshot command issued before the first snapshot is fully read is ignored.
- R5: A read-back byte (bits 7:6 = 11) acts on every counter whose select bit is set: bit 1 for counter 0, bit 2 for counter 1 and bit 3 for counter 2. Bit 5 low snapshots the count and bit 4 low snapshots the status. When both are held, the status byte is read first and the count bytes follow.
- R6: The status byte is {output level, null-count, control bits 5:0}. Null-count is set by a control write and by the completion of a count write. It clears when the count is moved into the counter.
- R7: Mode 000 (terminal-count interrupt): the output goes low when the count write completes. It goes high on the Nth decrementing `tick` after the loading `tick`, and it stays high until a new count or mode is written. `irq` always equals counter 0's output.
- R8: A reload value of zero is treated as 65536. In mode 000 the output stays low for 65536 decrementing ticks after loading.
- R9: Mode 011 (square wave): the counter decrements by two per `tick` and the output toggles each time the count expires. The output is high for (N+1)/2 ticks and low for N/2 ticks (integer division), so one period is N ticks. The output changes only on a `tick`.
- R10: Mode 100 (software strobe): the output is high. It goes low for exactly one `tick` on the Nth decrementing tick after loading, and it pulses only once per count written.
- R11: While a counter's `gate` is low its count holds. A pending load still completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register offset: 0..2 counter data, 3 control |
| wr_en | input | 1 | Write strobe for one clock |
| rd_en | input | 1 | Read strobe for one clock; advances the read byte order |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, valid while `rd_en` is high |
| tick | input | 1 | Count strobe shared by all counters |
| gate | input | 3 | Per-counter count enable |
| cnt_out | output | 3 | Per-counter output pins |
| irq | output | 1 | Interrupt request, equal to counter 0's output |

## Verification
The bench sweeps short reload values through the one-shot, strobe and square-wave modes and compares the output against the tick at which it should move, across every sampled cycle. A design that loads one tick early or late fails here. So does one that pulses its strobe twice, or one that rounds odd square-wave half periods the wrong way. Snapshot tests run the counter between the latch and the read, and they repeat the latch command. A design that reads live data, or re-snapshots on the second command, returns a different value. Read-back, gate hold, the null-count window and a zero reload of 65536 are checked at the exact tick where a mistaken design would differ.

// File: rtl/interval_timer.sv
module interval_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       tick,
  input  logic [2:0] gate,
  output logic [2:0] cnt_out,
  output logic       irq
);
  localparam int NCH = 3;
  localparam logic [1:0] AC_LAT = 2'd0, AC_LO = 2'd1, AC_HI = 2'd2, AC_LH = 2'd3;
  localparam logic [2:0] MD_SQ = 3'd3, MD_STB = 3'd4;

  logic [NCH-1:0][5:0]  ctrl_q;
  logic [NCH-1:0][15:0] cnt_q;
  logic [NCH-1:0][7:0]  rbyte;
  logic [NCH-1:0]       pend_q, nullc_q, out_q;

  logic wr_ctl, rb;
  assign wr_ctl  = wr_en && addr == 2'd3;
  assign rb      = wr_ctl && wdata[7:6] == 2'b11;
  assign cnt_out = out_q;
  assign irq     = out_q[0];
  assign rdata   = (addr == 2'd3) ? 8'h00 : rbyte[addr];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [5:0]  ctrl_r;
    logic [15:0] reload_r, cnt_r, lat_r;
    logic [7:0]  stg_r, st_r;
    logic        pend_r, nullc_r, armed_r, out_r, wr_hi_r, rd_hi_r, lat_v, st_v;

    logic [1:0]  acc;
    logic [2:0]  md;
    logic        sq, stb, term, sel, ctl_set, lat_cmd, rb_cnt, rb_st;
    logic        wr_dat, rd_dat, done, load_now, dec_now, expire, hi_sel;
    logic [15:0] nval, step, hiph, loph, src;

    assign acc      = ctrl_r[5:4];
    assign md       = ctrl_r[3:1];
    assign sq       = md == MD_SQ;
    assign stb      = md == MD_STB;
    assign term     = !sq && !stb;
    assign sel      = wr_ctl && wdata[7:6] == 2'(i);
    assign ctl_set  = sel && wdata[5:4] != AC_LAT;
    assign lat_cmd  = sel && wdata[5:4] == AC_LAT;
    assign rb_cnt   = rb && wdata[i+1] && !wdata[5];
    assign rb_st    = rb && wdata[i+1] && !wdata[4];
    assign wr_dat   = wr_en && addr == 2'(i);
    assign rd_dat   = rd_en && addr == 2'(i);
    assign done     = wr_dat && (acc != AC_LH || wr_hi_r);
    assign nval     = (acc == AC_LO) ? {8'h00, wdata} :
                      (acc == AC_HI) ? {wdata, 8'h00} : {wdata, stg_r};
    assign step     = sq ? 16'd2 : 16'd1;
    assign hiph     = reload_r + {15'd0, reload_r[0]};
    assign loph     = reload_r - {15'd0, reload_r[0]};
    assign load_now = tick && pend_r;
    assign dec_now  = tick && gate[i] && !pend_r;
    assign expire   = dec_now && cnt_r == step;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_r   <= '0;
        reload_r <= '0;
        cnt_r    <= '0;
        stg_r    <= '0;
        pend_r   <= 1'b0;
        nullc_r  <= 1'b1;
        armed_r  <= 1'b0;
        out_r    <= 1'b0;
        wr_hi_r  <= 1'b0;
      end else begin
        if (ctl_set) wr_hi_r <= 1'b0;
        else if (wr_dat && acc == AC_LH) wr_hi_r <= !wr_hi_r;
        if (wr_dat && acc == AC_LH && !wr_hi_r) stg_r <= wdata;

        if (load_now) cnt_r <= sq ? hiph : reload_r;
        else if (dec_now) cnt_r <= (sq && expire) ? (out_r ? loph : hiph) : cnt_r - step;

        if (ctl_set) begin
          ctrl_r  <= wdata[5:0];
          pend_r  <= 1'b0;
          nullc_r <= 1'b1;
          armed_r <= 1'b0;
          out_r   <= (wdata[3:1] == MD_SQ) || (wdata[3:1] == MD_STB);
        end else if (done) begin
          reload_r <= nval;
          pend_r   <= 1'b1;
          nullc_r  <= 1'b1;
          armed_r  <= 1'b0;
          if (term) out_r <= 1'b0;
        end else if (load_now) begin
          pend_r  <= 1'b0;
          nullc_r <= 1'b0;
          armed_r <= 1'b1;
          if (!term) out_r <= 1'b1;
        end else if (stb && !out_r && tick) begin
          out_r <= 1'b1;
        end else if (expire && armed_r) begin
          if (sq) out_r <= !out_r;
          else begin
            out_r   <= term;
            armed_r <= 1'b0;
          end
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lat_r   <= '0;
        lat_v   <= 1'b0;
        st_r    <= '0;
        st_v    <= 1'b0;
        rd_hi_r <= 1'b0;
      end else if (ctl_set) begin
        lat_v   <= 1'b0;
        st_v    <= 1'b0;
        rd_hi_r <= 1'b0;
      end else begin
        if ((lat_cmd || rb_cnt) && !lat_v) begin
          lat_r <= cnt_r;
          lat_v <= 1'b1;
        end
        if (rb_st && !st_v) begin
          st_r <= {out_r, nullc_r, ctrl_r};
          st_v <= 1'b1;
        end
        if (rd_dat) begin
          if (st_v) st_v <= 1'b0;
          else if (acc == AC_LH && !rd_hi_r) rd_hi_r <= 1'b1;
          else begin
            rd_hi_r <= 1'b0;
            lat_v   <= 1'b0;
          end
        end
      end
    end

    assign src      = lat_v ? lat_r : cnt_r;
    assign hi_sel   = acc == AC_HI || (acc == AC_LH && rd_hi_r);
    assign rbyte[i] = st_v ? st_r : (hi_sel ? src[15:8] : src[7:0]);
    assign ctrl_q[i]  = ctrl_r;
    assign cnt_q[i]   = cnt_r;
    assign pend_q[i]  = pend_r;
    assign nullc_q[i] = nullc_r;
    assign out_q[i]   = out_r;
  end
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [2:0]       gate,
  input logic [2:0]       cnt_out,
  input logic [2:0][5:0]  ctrl_q,
  input logic [2:0]       pend_q,
  input logic [2:0]       nullc_q,
  input logic [2:0][15:0] cnt_q
);
  for (genvar c = 0; c < 3; c++) begin : g_chk
    logic sqm, stm, tm, wr_c, wr_d;
    assign sqm  = ctrl_q[c][3:1] == 3'd3;
    assign stm  = ctrl_q[c][3:1] == 3'd4;
    assign tm   = !sqm && !stm;
    assign wr_c = wr_en && addr == 2'd3;
    assign wr_d = wr_en && addr == 2'(c);

    AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate[c] && !pend_q[c]) |=> $stable(cnt_q[c])); // R11
    AST_NULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[c] && tick && !wr_c && !wr_d) |=> !nullc_q[c]); // R6
    AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (stm && !cnt_out[c] && tick && !wr_c) |=> cnt_out[c]); // R10
    AST_TERM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tm && cnt_out[c] && !wr_c && !wr_d) |=> cnt_out[c]); // R7
    AST_SQ_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (sqm && !tick && !wr_c) |=> $stable(cnt_out[c])); // R9
  end
endmodule

bind interval_timer interval_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .gate(gate), .cnt_out(cnt_out), .ctrl_q(ctrl_q), .pend_q(pend_q),
  .nullc_q(nullc_q), .cnt_q(cnt_q)
);

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] gate = 3'b111;
  logic [2:0] cnt_out;
  logic irq;
  int total = 0, bad = 0;

  interval_timer u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .tick(tick), .gate(gate),
    .cnt_out(cnt_out), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rdc(input logic [1:0] a, input int exp, input string req);
    logic [7:0] d;
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
    chk(req, d, exp);
  endtask

  task automatic tick_n(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic shot(input bit strobe, input int n);
    int errs;
    bit expv;
    errs = 0;
    wr(2'd3, strobe ? 8'h78 : 8'h70);
    chk(strobe ? "R2 strobe start level" : "R2 one-shot start level", cnt_out[1], strobe);
    wr(2'd1, 8'(n)); wr(2'd1, 8'h00);
    @(negedge clk); tick = 1'b1;
    for (int k = 1; k <= n + 8; k++) begin
      @(negedge clk);
      expv = strobe ? (k != n + 1) : (k >= n + 1);
      if (cnt_out[1] != expv) errs++;
    end
    tick = 1'b0;
    chk(strobe ? "R10 strobe timing" : "R7 terminal timing", errs, 0);
  endtask

  task automatic square(input int n);
    logic [63:0] s;
    int irqerr, a, hi, lo, k;
    irqerr = 0;
    s = '0;
    wr(2'd3, 8'h36);
    chk("R2 square start level", cnt_out[0], 1);
    wr(2'd0, 8'(n)); wr(2'd0, 8'h00);
    @(negedge clk); tick = 1'b1;
    for (int j = 1; j <= 48; j++) begin
      @(negedge clk);
      s[j] = cnt_out[0];
      if (irq != cnt_out[0]) irqerr++;
    end
    tick = 1'b0;
    a = 0;
    for (int j = 2; j <= 48; j++) if (a == 0 && !s[j-1] && s[j]) a = j;
    hi = 0; lo = 0; k = a;
    while (k > 0 && k <= 48 && s[k]) begin hi++; k++; end
    while (k > 0 && k <= 48 && !s[k]) begin lo++; k++; end
    chk("R9 square high ticks", hi, (n + 1) / 2);
    chk("R9 square low ticks", lo, n / 2);
    chk("R7 irq follows counter 0", irqerr, 0);
  endtask

  initial begin
    #(8 * 190000);
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk("R1 outputs low", cnt_out, 0);
    chk("R1 irq low", irq, 0);
    wr(2'd3, 8'hE2); rdc(2'd0, 8'h40, "R1 status ch0");
    wr(2'd3, 8'hE8); rdc(2'd2, 8'h40, "R1 status ch2");

    // R7 mode 0 on counter 0, LH access
    wr(2'd3, 8'h30);
    chk("R2 mode0 level", cnt_out[0], 0);
    wr(2'd0, 8'h05);
    wr(2'd3, 8'hE2); rdc(2'd0, 8'h70, "R6 null after control");
    wr(2'd0, 8'h00);
    tick_n(1);
    wr(2'd3, 8'hE2); rdc(2'd0, 8'h30, "R6 null cleared");
    tick_n(4); chk("R7 before terminal", cnt_out[0], 0);
    tick_n(1); chk("R7 at terminal", cnt_out[0], 1);
    chk("R7 irq", irq, 1);
    tick_n(10); chk("R7 stays high", cnt_out[0], 1);
    rdc(2'd0, 8'hF6, "R3 live low byte");
    rdc(2'd0, 8'hFF, "R3 live high byte");

    // R4 latch on counter 1
    wr(2'd3, 8'h70); wr(2'd1, 8'h34); wr(2'd1, 8'h12);
    tick_n(1); tick_n(16);
    wr(2'd3, 8'h40);
    tick_n(5);
    wr(2'd3, 8'h40);
    rdc(2'd1, 8'h24, "R4 snapshot low");
    rdc(2'd1, 8'h12, "R4 snapshot high");
    rdc(2'd1, 8'h1F, "R4 live low after snapshot");
    rdc(2'd1, 8'h12, "R4 live high after snapshot");

    // R5 read-back with status and count
    wr(2'd3, 8'hC4);
    rdc(2'd1, 8'h30, "R5 status first");
    rdc(2'd1, 8'h1F, "R5 count low");
    rdc(2'd1, 8'h12, "R5 count high");

    // R3 access modes on counter 2
    wr(2'd3, 8'h90); wr(2'd2, 8'h07);
    tick_n(1); rdc(2'd2, 8'h07, "R3 low-only read");
    tick_n(6); chk("R3 low-only count before end", cnt_out[2], 0);
    tick_n(1); chk("R3 low-only count end", cnt_out[2], 1);
    wr(2'd3, 8'hA0);
    chk("R2 mode write drops output", cnt_out[2], 0);
    wr(2'd2, 8'h02);
    tick_n(1); rdc(2'd2, 8'h02, "R3 high-only read");
    tick_n(1); rdc(2'd2, 8'h01, "R3 high-only after step");

    // R5 multi-counter count latch
    wr(2'd3, 8'hDC);
    tick_n(3);
    rdc(2'd1, 8'h15, "R5 multi ch1 low");
    rdc(2'd1, 8'h12, "R5 multi ch1 high");
    rdc(2'd2, 8'h01, "R5 multi ch2 high");

    // R6 null window
    wr(2'd0, 8'h09); wr(2'd0, 8'h00);
    wr(2'd3, 8'hE2); rdc(2'd0, 8'h70, "R6 null after count write");
    tick_n(1);
    wr(2'd3, 8'hE2); rdc(2'd0, 8'h30, "R6 null after load");

    // R11 gate
    wr(2'd0, 8'h03); wr(2'd0, 8'h00);
    gate[0] = 1'b0;
    tick_n(1); tick_n(10);
    chk("R11 held output", cnt_out[0], 0);
    rdc(2'd0, 8'h03, "R11 held count low");
    rdc(2'd0, 8'h00, "R11 held count high");
    gate[0] = 1'b1;
    tick_n(2); chk("R11 resumed before end", cnt_out[0], 0);
    tick_n(1); chk("R11 resumed end", cnt_out[0], 1);

    // R8 zero reload
    wr(2'd3, 8'h90); wr(2'd2, 8'h00);
    tick_n(1); tick_n(65535);
    chk("R8 65535 ticks low", cnt_out[2], 0);
    tick_n(1);
    chk("R8 65536 ticks high", cnt_out[2], 1);

    // R7 and R10 sweeps
    for (int n = 1; n <= 6; n++) shot(1'b0, n);
    for (int n = 1; n <= 6; n++) shot(1'b1, n);

    // R9 sweep
    for (int n = 2; n <= 9; n++) square(n);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule